// File: doc/BRIEF.md
# Pseudo-SRAM Sleep and Standby Mode Controller

This block is the device-side controller that decides which power state a pseudo-SRAM die is in. It watches the chip-select, the sleep pin and the two byte enables, together with three configuration fields. From these it tracks a timed power-on lockout, the initial state, active and standby operation, and two sleep states. The first sleep state is partial-array retention, which keeps refreshing only a selected part of the array. The second is deep power-down, where refresh stops altogether.

For each quarter of the array, the block reports whether the contents survived the most recent sleep. When the die leaves deep power-down, it also issues a one-cycle request that returns the configuration register to its default. All waits are counted in clock cycles, derived from a clock-rate parameter given in MHz, so a simulation can shrink them. The memory array, the refresh engine and the data path sit outside this block.

The quarter flags describe the outcome of the latest sleep. They read all zero during the lockout, become all ones when the lockout ends, and are replaced on each partial-retention or deep power-down entry. They are not touched in any other state.

Top module: `psram_sleep_ctrl`

## Requirements
- R1: After reset the mode code is 0 (locked) for exactly CLK_MHZ*LOCK_US cycles, then becomes 1 (initial). The quarter flags are 4'b0000 while locked and 4'b1111 from the first initial cycle.
- R2: From initial, active or standby, the mode changes on the next edge as follows. Chip-select low (chip_en_n=0) with sleep_n=1 and at least one byte_en_n bit low gives mode 2 (active). Chip-select high with sleep_n=1 gives mode 3 (standby). Chip-select low with both byte enables high leaves the mode unchanged, and sleep_n=0 while chip-select is low never starts a sleep.
- R3: From initial, active or standby, sleep_n=0 with chip-select high selects the next mode from cfg_retain_on. A value of 1 gives mode 5 (partial retention); a value of 0 gives mode 4 (deep power-down arming).
- R4: On entry to mode 5 the flags take the retention mask; flag bit i covers the quarter whose two top address bits equal i. cfg_retain_size 00 keeps four quarters, 01 keeps three, 10 keeps two and 11 keeps one. cfg_retain_top=0 keeps the lowest-numbered quarters and cfg_retain_top=1 keeps the highest-numbered.
- R5: In mode 4, sleep_n held low for CLK_MHZ*DPD_US cycles counted from entry gives mode 6 (deep power-down) with flags 4'b0000. sleep_n going high earlier returns to mode 3 with the flags unchanged.
- R6: sleep_n=1 in mode 6 gives mode 7 (recovery) with cfg_default_req high in exactly that first cycle. Mode 7 lasts CLK_MHZ*RECOV_US cycles, then the mode becomes 3.
- R7: sleep_n=1 in mode 5 gives mode 3 on the next edge, with the flags unchanged.
- R8: In modes 4, 5 and 6, chip-select and byte enables change neither the mode nor access_err.
- R9: Every cycle with chip-select low while in mode 0 or mode 7 raises access_err in the following cycle. access_err is 0 in all other cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power applied) |
| chip_en_n | input | 1 | Chip select, active low |
| sleep_n | input | 1 | Sleep pin, low requests a sleep state |
| byte_en_n | input | 2 | Byte enables, active low (bit 0 low byte, bit 1 high byte) |
| cfg_retain_on | input | 1 | 1 selects partial retention, 0 selects deep power-down |
| cfg_retain_top | input | 1 | Retained region anchored at the top (1) or bottom (0) |
| cfg_retain_size | input | 2 | Retained size: 00 all, 01 three quarters, 10 half, 11 one quarter |
| mode | output | 3 | Current mode code (0 to 7) |
| quarter_ok | output | 4 | Per-quarter data-retained flags |
| cfg_default_req | output | 1 | One-cycle request to restore the configuration default |
| access_err | output | 1 | Access attempted during lockout or recovery |

## Verification
The bench goes after the off-by-one edges of the three waits: it samples the cycle before each timed exit and the cycle of the exit itself. A counter that ends one cycle early or late shows up as the wrong mode code. It sweeps every anchor and size of the retention mask, so a shifted or inverted mask decode gives wrong flags. It also aborts a deep power-down arming early, where a design that forgets to abort would wrongly clear the flags. Finally, it drives chip-select during each sleep state and during recovery. This catches a controller that wakes up on a sleep-time access, misses the lockout error, or stretches the configuration-default pulse.

// File: rtl/sleepctl_pkg.sv
package sleepctl_pkg;

  localparam int NQ = 4;

  typedef enum logic [2:0] {
    PS_LOCK    = 3'd0,
    PS_INIT    = 3'd1,
    PS_ACTIVE  = 3'd2,
    PS_STANDBY = 3'd3,
    PS_ARM     = 3'd4,
    PS_PARTIAL = 3'd5,
    PS_DEEP    = 3'd6,
    PS_RECOVER = 3'd7
  } psm_state_e;

endpackage

// File: rtl/sleep_interval_timer.sv
module sleep_interval_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart_i,
  input  logic [CW-1:0] limit_i,
  output logic          expired_o
);

  logic [CW-1:0] cnt;

  // expired while the count sits on the last cycle of the window
  assign expired_o = (cnt == (limit_i - CW'(1)));

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      cnt <= '0;
    end else if (!expired_o) begin
      cnt <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/retain_mask_dec.sv
module retain_mask_dec
  import sleepctl_pkg::*;
(
  input  logic          top_i,
  input  logic [1:0]    size_i,
  output logic [NQ-1:0] mask_o
);

  logic [2:0] keep_n;

  assign keep_n = (size_i == 2'd0) ? 3'd4 : (3'd4 - {1'b0, size_i});

  for (genvar g = 0; g < NQ; g++) begin : g_quarter
    assign mask_o[g] = top_i ? (3'(g) >= (3'(NQ) - keep_n))
                             : (3'(g) < keep_n);
  end

endmodule

// File: rtl/psram_sleep_ctrl.sv
module psram_sleep_ctrl
  import sleepctl_pkg::*;
#(
  parameter int CLK_MHZ  = 125,
  parameter int LOCK_US  = 200,
  parameter int DPD_US   = 10,
  parameter int RECOV_US = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       chip_en_n,
  input  logic       sleep_n,
  input  logic [1:0] byte_en_n,
  input  logic       cfg_retain_on,
  input  logic       cfg_retain_top,
  input  logic [1:0] cfg_retain_size,
  output logic [2:0] mode,
  output logic [3:0] quarter_ok,
  output logic       cfg_default_req,
  output logic       access_err
);

  localparam int LOCK_CYC  = CLK_MHZ * LOCK_US;
  localparam int DPD_CYC   = CLK_MHZ * DPD_US;
  localparam int RECOV_CYC = CLK_MHZ * RECOV_US;
  localparam int MAX_A     = (LOCK_CYC > DPD_CYC) ? LOCK_CYC : DPD_CYC;
  localparam int MAX_CYC   = (MAX_A > RECOV_CYC) ? MAX_A : RECOV_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  psm_state_e       state, state_nx;
  logic [CNT_W-1:0] win_limit;
  logic             tmr_done;
  logic [NQ-1:0]    keep_mask;
  logic             any_byte;

  assign any_byte = (byte_en_n != 2'b11);

  retain_mask_dec u_mask (
    .top_i  (cfg_retain_top),
    .size_i (cfg_retain_size),
    .mask_o (keep_mask)
  );

  always_comb begin
    case (state)
      PS_LOCK:    win_limit = CNT_W'(LOCK_CYC);
      PS_ARM:     win_limit = CNT_W'(DPD_CYC);
      PS_RECOVER: win_limit = CNT_W'(RECOV_CYC);
      default:    win_limit = CNT_W'(1);
    endcase
  end

  sleep_interval_timer #(.CW(CNT_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .restart_i (state_nx != state),
    .limit_i   (win_limit),
    .expired_o (tmr_done)
  );

  always_comb begin
    state_nx = state;
    case (state)
      PS_LOCK: if (tmr_done) state_nx = PS_INIT;
      PS_INIT, PS_ACTIVE, PS_STANDBY: begin
        if (chip_en_n && !sleep_n)
          state_nx = cfg_retain_on ? PS_PARTIAL : PS_ARM;
        else if (!chip_en_n && sleep_n && any_byte)
          state_nx = PS_ACTIVE;
        else if (chip_en_n && sleep_n)
          state_nx = PS_STANDBY;
      end
      PS_ARM: begin
        if (sleep_n) state_nx = PS_STANDBY;
        else if (tmr_done) state_nx = PS_DEEP;
      end
      PS_PARTIAL: if (sleep_n) state_nx = PS_STANDBY;
      PS_DEEP:    if (sleep_n) state_nx = PS_RECOVER;
      PS_RECOVER: if (tmr_done) state_nx = PS_STANDBY;
      default:    state_nx = PS_LOCK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= PS_LOCK;
      quarter_ok      <= '0;
      cfg_default_req <= 1'b0;
      access_err      <= 1'b0;
    end else begin
      state           <= state_nx;
      cfg_default_req <= (state == PS_DEEP) && (state_nx == PS_RECOVER);
      access_err      <= ((state == PS_LOCK) || (state == PS_RECOVER)) && !chip_en_n;
      if (state == PS_LOCK && state_nx == PS_INIT)
        quarter_ok <= '1;
      else if (state != PS_PARTIAL && state_nx == PS_PARTIAL)
        quarter_ok <= keep_mask;
      else if (state != PS_DEEP && state_nx == PS_DEEP)
        quarter_ok <= '0;
    end
  end

  assign mode = state;

  // lockout never ends before the timer reports the window complete
  assert_lock_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (state == PS_LOCK && !tmr_done) |=> (state == PS_LOCK));

  // entering partial retention needs the retention choice in the configuration
  assert_partial_cfg_R3: assert property (@(posedge clk) disable iff (rst)
    (state == PS_PARTIAL && $past(state) != PS_PARTIAL) |-> $past(cfg_retain_on));

  // retained quarter count matches the configured size
  assert_mask_count_R4: assert property (@(posedge clk) disable iff (rst)
    (state == PS_PARTIAL && $past(state) != PS_PARTIAL) |->
      ($countones(quarter_ok) == (($past(cfg_retain_size) == 2'd0) ? 4 : 4 - int'($past(cfg_retain_size)))));

  // deep power-down holds no valid quarter
  assert_deep_flags_R5: assert property (@(posedge clk) disable iff (rst)
    (state == PS_DEEP) |-> (quarter_ok == '0));

  // configuration default request only on the first recovery cycle
  assert_cfgreq_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_default_req |-> (state == PS_RECOVER && $past(state) == PS_DEEP));

  // leaving partial retention lands in standby
  assert_partial_exit_R7: assert property (@(posedge clk) disable iff (rst)
    (state == PS_PARTIAL && sleep_n) |=> (state == PS_STANDBY));

  // errors come only from a select during lockout or recovery
  assert_err_source_R9: assert property (@(posedge clk) disable iff (rst)
    access_err |-> (($past(state) == PS_LOCK || $past(state) == PS_RECOVER) && !$past(chip_en_n)));

endmodule

// File: tb/psram_sleep_ctrl_bench.sv
`timescale 1ns/1ps
module psram_sleep_ctrl_bench;

  localparam int CLK_MHZ = 1;
  localparam int LOCKC   = CLK_MHZ * 200;
  localparam int DPDC    = CLK_MHZ * 10;
  localparam int RECC    = CLK_MHZ * 200;

  logic       clk = 1'b0;
  logic       rst;
  logic       chip_en_n, sleep_n;
  logic [1:0] byte_en_n;
  logic       cfg_retain_on, cfg_retain_top;
  logic [1:0] cfg_retain_size;
  logic [2:0] mode;
  logic [3:0] quarter_ok;
  logic       cfg_default_req, access_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  psram_sleep_ctrl #(.CLK_MHZ(CLK_MHZ)) u_psram_sleep_ctrl (
    .clk             (clk),
    .rst             (rst),
    .chip_en_n       (chip_en_n),
    .sleep_n         (sleep_n),
    .byte_en_n       (byte_en_n),
    .cfg_retain_on   (cfg_retain_on),
    .cfg_retain_top  (cfg_retain_top),
    .cfg_retain_size (cfg_retain_size),
    .mode            (mode),
    .quarter_ok      (quarter_ok),
    .cfg_default_req (cfg_default_req),
    .access_err      (access_err)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_mask(input int top, input int sz);
    int n, m;
    n = (sz == 0) ? 4 : 4 - sz;
    m = (1 << n) - 1;
    if (top != 0) m = (m << (4 - n)) & 15;
    return m;
  endfunction

  initial begin
    rst = 1'b1; chip_en_n = 1'b1; sleep_n = 1'b1; byte_en_n = 2'b11;
    cfg_retain_on = 1'b1; cfg_retain_top = 1'b0; cfg_retain_size = 2'b00;
    step(3);
    chk("R1 reset mode", int'(mode), 0);
    chk("R1 reset flags", int'(quarter_ok), 0);
    chk("R6 reset req", int'(cfg_default_req), 0);
    chk("R9 reset err", int'(access_err), 0);

    // lockout window with one rejected access
    rst = 1'b0;
    step(50);
    chk("R1 locked", int'(mode), 0);
    chip_en_n = 1'b0;
    step(1);
    chk("R9 err in lockout", int'(access_err), 1);
    chk("R1 still locked", int'(mode), 0);
    chip_en_n = 1'b1;
    step(1);
    chk("R9 err clears", int'(access_err), 0);
    step(LOCKC - 1 - 52);
    chk("R1 last locked cycle", int'(mode), 0);
    step(1);
    chk("R1 initial", int'(mode), 1);
    chk("R1 flags set", int'(quarter_ok), 15);

    // active and standby decode
    chip_en_n = 1'b0; byte_en_n = 2'b11;
    step(1);
    chk("R2 no byte enable", int'(mode), 1);
    byte_en_n = 2'b10;
    step(1);
    chk("R2 active", int'(mode), 2);
    sleep_n = 1'b0;
    step(1);
    chk("R2 no sleep with select low", int'(mode), 2);
    sleep_n = 1'b1; chip_en_n = 1'b1; byte_en_n = 2'b11;
    step(1);
    chk("R2 standby", int'(mode), 3);

    // partial retention sweep over anchor and size
    for (int top = 0; top < 2; top++) begin
      for (int sz = 0; sz < 4; sz++) begin
        cfg_retain_on = 1'b1;
        cfg_retain_top = top[0];
        cfg_retain_size = sz[1:0];
        sleep_n = 1'b0;
        step(1);
        chk("R3 partial entry", int'(mode), 5);
        chk("R4 retention mask", int'(quarter_ok), exp_mask(top, sz));
        chip_en_n = 1'b0; byte_en_n = 2'b00;
        step(1);
        chk("R8 partial ignores select", int'(mode), 5);
        chk("R8 partial no error", int'(access_err), 0);
        chip_en_n = 1'b1; byte_en_n = 2'b11; sleep_n = 1'b1;
        step(1);
        chk("R7 partial exit", int'(mode), 3);
        chk("R7 flags kept", int'(quarter_ok), exp_mask(top, sz));
      end
    end

    // deep power-down arming aborted early
    cfg_retain_on = 1'b0;
    sleep_n = 1'b0;
    step(1);
    chk("R3 arm entry", int'(mode), 4);
    chip_en_n = 1'b0;
    step(1);
    chk("R8 arm ignores select", int'(mode), 4);
    chk("R8 arm no error", int'(access_err), 0);
    chip_en_n = 1'b1;
    step(3);
    sleep_n = 1'b1;
    step(1);
    chk("R5 abort to standby", int'(mode), 3);
    chk("R5 abort keeps flags", int'(quarter_ok), exp_mask(1, 3));

    // full deep power-down
    sleep_n = 1'b0;
    step(1);
    chk("R5 arm again", int'(mode), 4);
    step(DPDC - 1);
    chk("R5 last arm cycle", int'(mode), 4);
    step(1);
    chk("R5 deep", int'(mode), 6);
    chk("R5 flags cleared", int'(quarter_ok), 0);
    chip_en_n = 1'b0; byte_en_n = 2'b00;
    step(1);
    chk("R8 deep ignores select", int'(mode), 6);
    chk("R8 deep no error", int'(access_err), 0);
    chip_en_n = 1'b1; byte_en_n = 2'b11; sleep_n = 1'b1;
    step(1);
    chk("R6 recovery", int'(mode), 7);
    chk("R6 default request", int'(cfg_default_req), 1);
    step(1);
    chk("R6 request one cycle", int'(cfg_default_req), 0);
    chip_en_n = 1'b0;
    step(1);
    chk("R9 err in recovery", int'(access_err), 1);
    chip_en_n = 1'b1;
    step(1);
    chk("R9 err clears again", int'(access_err), 0);
    step(RECC - 1 - 3);
    chk("R6 last recovery cycle", int'(mode), 7);
    step(1);
    chk("R6 back to standby", int'(mode), 3);
    chip_en_n = 1'b0; byte_en_n = 2'b01;
    step(1);
    chk("R2 active after recovery", int'(mode), 2);
    chk("R9 no error when open", int'(access_err), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule